// File: doc/BRIEF.md
# Processor Operating-State and Power-Mode Controller

This block tracks the top-level operating state of a small 32-bit processor core. It holds one of eight states: hardware standby, power-on reset, manual reset, exception handling, program execution, bus released, sleep and software standby. It moves between them according to two active-low reset pins, an active-low hardware-standby pin, a bus request, an interrupt request, a one-cycle sleep-instruction strobe with a standby-select bit, and a one-cycle end-of-exception strobe. The instruction pipeline, interrupt arbitration and real clock gating sit outside the block and reach it only as these flags and strobes.

The block reports its state as a one-hot vector. It also drives the privileged/user mode bit, a bus-grant acknowledge and a clock-stop indication. All inputs are sampled on the rising clock edge, and every output follows a registered state. A change on an input therefore shows at the outputs one cycle later. A synchronous active-high `rst` puts the machine in the power-on reset state.

Top module: `proc_state_ctrl`

## Requirements
- R1: With `hw_stby_n` low at a clock edge, the next state is hardware standby, whatever the current state and all other inputs.
- R2: With `hw_stby_n` high and `pwr_rst_n` low, the next state is power-on reset, from any state including hardware standby. Once `pwr_rst_n` is high again, the power-on reset state moves to exception handling.
- R3: With both of those pins high and `man_rst_n` low, the next state is manual reset, unless the machine is in hardware standby, where `man_rst_n` has no effect. Once `man_rst_n` is high, the manual reset state moves to exception handling.
- R4: A `sleep_ins` strobe in program execution enters sleep when `stby_sel` is 0, and software standby when `stby_sel` is 1. In any other state it has no effect.
- R5: `irq` high moves program execution, sleep or software standby to exception handling. In the other states it has no effect.
- R6: `bus_req` high in program execution, exception handling or sleep enters bus released. While in bus released, `bus_ack` is 1. When `bus_req` drops, the machine returns to the state it left, so a request taken during sleep comes back to sleep. In software standby, `bus_req` has no effect.
- R7: `priv_mode` becomes 1 on entry to power-on reset, manual reset or exception handling. It becomes 0 when an `exc_end` strobe moves exception handling to program execution. It holds its value on every other transition.
- R8: When several requests are present together, they act in this order, highest first: hardware standby, power-on reset, manual reset, interrupt, bus request, sleep instruction. In exception handling, a bus request comes before `exc_end`.
- R9: `clk_stop` is 1 in software standby and hardware standby, and 0 in every other state, sleep included.
- R10: `rst` high at a clock edge puts the machine in power-on reset with `priv_mode` = 1.
- R11: `state_oh` has exactly one bit set. The bit positions are: 0 hardware standby, 1 power-on reset, 2 manual reset, 3 exception handling, 4 program execution, 5 bus released, 6 sleep, 7 software standby.
- R12: Hardware standby is left only when `hw_stby_n` is high and `pwr_rst_n` is low. With `pwr_rst_n` high, all other inputs leave the machine in hardware standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_rst_n | input | 1 | Power-on reset request, active low |
| man_rst_n | input | 1 | Manual reset request, active low |
| hw_stby_n | input | 1 | Hardware standby request, active low |
| bus_req | input | 1 | External bus-release request, level |
| irq | input | 1 | Interrupt request, level |
| sleep_ins | input | 1 | Sleep instruction executed, one-cycle strobe |
| stby_sel | input | 1 | Selects software standby (1) or sleep (0) for `sleep_ins` |
| exc_end | input | 1 | End of exception handling, one-cycle strobe |
| state_oh | output | 8 | One-hot current state |
| priv_mode | output | 1 | 1 = privileged, 0 = user |
| bus_ack | output | 1 | Bus released to the external requester |
| clk_stop | output | 1 | Core clock may be stopped |

## Verification
A wrong next-state decision shows on `state_oh` at the very next edge, because every output is decoded from the state register with no further delay. A corrupted bus-return state stays hidden while `bus_req` is held. It appears in the cycle after the request drops, when the machine lands in the wrong state. A mode bit that is set or cleared at the wrong moment shows on `priv_mode` in the same cycle as the faulty transition. The bench compares all four outputs with its reference model on every cycle, so any of these faults is reported within one cycle of first becoming visible.

// File: rtl/proc_state_pkg.sv
package proc_state_pkg;

    localparam int NUM_STATES = 8;
    localparam int STATE_W    = $clog2(NUM_STATES);

    // Encoding value equals the one-hot bit position on state_oh.
    typedef enum logic [STATE_W-1:0] {
        ST_HW_STBY = 3'd0,
        ST_POR     = 3'd1,
        ST_MRST    = 3'd2,
        ST_EXC     = 3'd3,
        ST_PROG    = 3'd4,
        ST_BUSREL  = 3'd5,
        ST_SLEEP   = 3'd6,
        ST_SW_STBY = 3'd7
    } pstate_e;

    // Requests normalised to active-high.
    typedef struct packed {
        logic hw_stby;
        logic pwr_rst;
        logic man_rst;
        logic irq;
        logic bus;
        logic sleep;
        logic stby_sel;
        logic exc_end;
    } req_t;

    function automatic logic forces_priv(pstate_e s);
        return (s == ST_POR) || (s == ST_MRST) || (s == ST_EXC);
    endfunction

    function automatic logic is_clk_off(pstate_e s);
        return (s == ST_SW_STBY) || (s == ST_HW_STBY);
    endfunction

    function automatic logic can_release_bus(pstate_e s);
        return (s == ST_PROG) || (s == ST_EXC) || (s == ST_SLEEP);
    endfunction

endpackage

// File: rtl/psc_req_norm.sv
module psc_req_norm
    import proc_state_pkg::*;
(
    input  logic pwr_rst_n,
    input  logic man_rst_n,
    input  logic hw_stby_n,
    input  logic bus_req,
    input  logic irq,
    input  logic sleep_ins,
    input  logic stby_sel,
    input  logic exc_end,
    output req_t req
);
    always_comb begin
        req.hw_stby  = ~hw_stby_n;
        req.pwr_rst  = ~pwr_rst_n;
        req.man_rst  = ~man_rst_n;
        req.irq      = irq;
        req.bus      = bus_req;
        req.sleep    = sleep_ins;
        req.stby_sel = stby_sel;
        req.exc_end  = exc_end;
    end
endmodule

// File: rtl/psc_next_state.sv
module psc_next_state
    import proc_state_pkg::*;
(
    input  pstate_e cur,
    input  pstate_e ret,
    input  req_t    req,
    output pstate_e nxt,
    output logic    save_ret
);
    always_comb begin
        nxt      = cur;
        save_ret = 1'b0;
        if (req.hw_stby) begin
            nxt = ST_HW_STBY;
        end else if (req.pwr_rst) begin
            nxt = ST_POR;
        end else if (cur == ST_HW_STBY) begin
            nxt = ST_HW_STBY;
        end else if (req.man_rst) begin
            nxt = ST_MRST;
        end else begin
            unique case (cur)
                ST_POR, ST_MRST: nxt = ST_EXC;
                ST_EXC: begin
                    if (req.bus) begin
                        nxt      = ST_BUSREL;
                        save_ret = 1'b1;
                    end else if (req.exc_end) begin
                        nxt = ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (req.irq) begin
                        nxt = ST_EXC;
                    end else if (req.bus) begin
                        nxt      = ST_BUSREL;
                        save_ret = 1'b1;
                    end else if (req.sleep) begin
                        nxt = req.stby_sel ? ST_SW_STBY : ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (req.irq) begin
                        nxt = ST_EXC;
                    end else if (req.bus) begin
                        nxt      = ST_BUSREL;
                        save_ret = 1'b1;
                    end
                end
                ST_SW_STBY: begin
                    if (req.irq) nxt = ST_EXC;
                end
                ST_BUSREL: begin
                    if (!req.bus) nxt = ret;
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/psc_out_decode.sv
module psc_out_decode
    import proc_state_pkg::*;
#(
    parameter int N = NUM_STATES
) (
    input  pstate_e        cur,
    output logic [N-1:0]   state_oh,
    output logic           bus_ack,
    output logic           clk_stop
);
    localparam int SW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_oh
        assign state_oh[i] = (cur == pstate_e'(SW'(i)));
    end

    assign bus_ack  = (cur == ST_BUSREL);
    assign clk_stop = is_clk_off(cur);
endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl
    import proc_state_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_rst_n,
    input  logic                  man_rst_n,
    input  logic                  hw_stby_n,
    input  logic                  bus_req,
    input  logic                  irq,
    input  logic                  sleep_ins,
    input  logic                  stby_sel,
    input  logic                  exc_end,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  priv_mode,
    output logic                  bus_ack,
    output logic                  clk_stop
);
    req_t    req;
    pstate_e cur_q, ret_q, nxt;
    logic    save_ret;
    logic    mode_q;

    psc_req_norm u_norm (
        .pwr_rst_n (pwr_rst_n),
        .man_rst_n (man_rst_n),
        .hw_stby_n (hw_stby_n),
        .bus_req   (bus_req),
        .irq       (irq),
        .sleep_ins (sleep_ins),
        .stby_sel  (stby_sel),
        .exc_end   (exc_end),
        .req       (req)
    );

    psc_next_state u_nxt (
        .cur      (cur_q),
        .ret      (ret_q),
        .req      (req),
        .nxt      (nxt),
        .save_ret (save_ret)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= ST_POR;
            ret_q  <= ST_PROG;
            mode_q <= 1'b1;
        end else begin
            cur_q <= nxt;
            if (save_ret) ret_q <= cur_q;
            if (forces_priv(nxt))
                mode_q <= 1'b1;
            else if (cur_q == ST_EXC && nxt == ST_PROG)
                mode_q <= 1'b0;
        end
    end

    psc_out_decode #(.N(NUM_STATES)) u_dec (
        .cur      (cur_q),
        .state_oh (state_oh),
        .bus_ack  (bus_ack),
        .clk_stop (clk_stop)
    );

    assign priv_mode = mode_q;

    // R1
    hw_stby_force_chk: assert property (@(posedge clk) disable iff (rst)
        !hw_stby_n |=> state_oh[0]);

    // R2
    por_force_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_stby_n && !pwr_rst_n) |=> state_oh[1]);

    // R12
    hw_stby_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_oh[0] && hw_stby_n && pwr_rst_n) |=> state_oh[0]);

    // R6
    bus_return_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_req && hw_stby_n && pwr_rst_n && man_rst_n)
        |=> (cur_q == $past(ret_q)));

    // R7
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_oh[4] && $past(state_oh[3])) |-> !priv_mode);

    // R7
    mode_set_chk: assert property (@(posedge clk) disable iff (rst)
        (state_oh[1] || state_oh[2] || state_oh[3]) |-> priv_mode);

    // R9
    sleep_clk_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[6] |-> !clk_stop);

    // R11
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

endmodule

// File: tb/proc_state_ctrl_tb.sv
module proc_state_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_rst_n = 1'b1, man_rst_n = 1'b1, hw_stby_n = 1'b1;
    logic bus_req = 1'b0, irq = 1'b0, sleep_ins = 1'b0, stby_sel = 1'b0, exc_end = 1'b0;
    logic [7:0] state_oh;
    logic priv_mode, bus_ack, clk_stop;

    always #2.5 clk = ~clk;

    proc_state_ctrl u_dut (
        .clk(clk), .rst(rst), .pwr_rst_n(pwr_rst_n), .man_rst_n(man_rst_n),
        .hw_stby_n(hw_stby_n), .bus_req(bus_req), .irq(irq),
        .sleep_ins(sleep_ins), .stby_sel(stby_sel), .exc_end(exc_end),
        .state_oh(state_oh), .priv_mode(priv_mode), .bus_ack(bus_ack),
        .clk_stop(clk_stop)
    );

    // Reference model: state numbers are the one-hot bit positions of R11.
    int ms = 1;
    int mm = 1;
    int rq[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R10";

    task automatic model_step();
        int ns;
        if (rst) begin
            ms = 1; mm = 1; rq.delete();
            return;
        end
        ns = ms;
        if (!hw_stby_n) ns = 0;
        else if (!pwr_rst_n) ns = 1;
        else if (ms == 0) ns = 0;
        else if (!man_rst_n) ns = 2;
        else if (ms == 1 || ms == 2) ns = 3;
        else if (ms == 3) begin
            if (bus_req) begin rq.delete(); rq.push_back(3); ns = 5; end
            else if (exc_end) ns = 4;
        end else if (ms == 4) begin
            if (irq) ns = 3;
            else if (bus_req) begin rq.delete(); rq.push_back(4); ns = 5; end
            else if (sleep_ins) ns = stby_sel ? 7 : 6;
        end else if (ms == 6) begin
            if (irq) ns = 3;
            else if (bus_req) begin rq.delete(); rq.push_back(6); ns = 5; end
        end else if (ms == 7) begin
            if (irq) ns = 3;
        end else if (ms == 5) begin
            if (!bus_req) ns = rq.pop_back();
        end
        if (ns == 1 || ns == 2 || ns == 3) mm = 1;
        else if (ms == 3 && ns == 4) mm = 0;
        ms = ns;
    endtask

    task automatic check1(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check1("state_oh", int'(state_oh), 1 << ms);
        check1("priv_mode", int'(priv_mode), mm);
        check1("bus_ack", int'(bus_ack), (ms == 5) ? 1 : 0);
        check1("clk_stop", int'(clk_stop), (ms == 0 || ms == 7) ? 1 : 0);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
            sleep_ins = 1'b0;
            exc_end   = 1'b0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        tick(2);                          // R10 reset state, R11 encoding
        rst = 1'b0;
        tag = "R2";  tick(1);             // POR released -> exception
        tag = "R7";  exc_end = 1; tick(1);// -> program, user mode
        tag = "R4";  sleep_ins = 1; stby_sel = 0; tick(1);
        tag = "R9";  tick(1);             // sleep keeps clock
        tag = "R6";  bus_req = 1; tick(3);
        bus_req = 0; tick(1);             // back to sleep
        tag = "R5";  irq = 1; tick(1); irq = 0;
        tag = "R8";  bus_req = 1; exc_end = 1; tick(1); // bus wins over exc_end
        bus_req = 0; tick(1);             // back to exception
        tag = "R7";  exc_end = 1; tick(1);
        tag = "R4";  sleep_ins = 1; stby_sel = 1; tick(1); // software standby
        tag = "R6";  bus_req = 1; tick(2); bus_req = 0;    // ignored
        tag = "R5";  irq = 1; tick(1); irq = 0;
        exc_end = 1; tick(1);
        tag = "R5";  sleep_ins = 1; tick(1);                // ignored in exception? no: in program; now standby
        irq = 1; tick(1); irq = 0;
        tag = "R3";  man_rst_n = 0; tick(2); man_rst_n = 1; tick(1);
        tag = "R1";  exc_end = 1; tick(1); hw_stby_n = 0; tick(2);
        hw_stby_n = 1;
        tag = "R12"; man_rst_n = 0; irq = 1; bus_req = 1; tick(3);
        man_rst_n = 1; irq = 0; bus_req = 0; tick(1);
        tag = "R2";  pwr_rst_n = 0; tick(2); pwr_rst_n = 1; tick(2);
        tag = "R8";  hw_stby_n = 0; pwr_rst_n = 0; man_rst_n = 0; tick(1);
        hw_stby_n = 1; tick(1); pwr_rst_n = 1; tick(1); man_rst_n = 1; tick(1);
        exc_end = 1; tick(1);
        irq = 1; bus_req = 1; sleep_ins = 1; tick(1); irq = 0; tick(2); bus_req = 0; tick(1);
        tag = "R10"; rst = 1; tick(1); rst = 0; tick(1);
        tag = "R8";
        for (int k = 0; k < 4000; k++) begin
            hw_stby_n = ($urandom_range(0, 99) != 0);
            pwr_rst_n = ($urandom_range(0, 49) != 0);
            man_rst_n = ($urandom_range(0, 49) != 0);
            irq       = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 5) == 0) bus_req = ~bus_req;
            sleep_ins = ($urandom_range(0, 5) == 0);
            stby_sel  = $urandom_range(0, 1);
            exc_end   = ($urandom_range(0, 2) == 0);
            tick(1);
        end
        summary();
    end
endmodule